// File: doc/BRIEF.md
# Out-of-Order Issue Window

This block sits between decode and a set of functional units. Decoded instructions arrive one per cycle in program order and are written into a small buffer. An instruction that cannot start does not hold up the ones behind it: new instructions are accepted while a free slot remains. Every cycle the window works out which buffered instructions are ready. An instruction is ready when its target unit is idle and it has no register hazard against older work. The window then starts at most one ready instruction per unit, in any program order.

Registers are not renamed, so the window itself keeps the architectural registers correct. It stops reads that would see a stale value, writes that would clobber a value an older instruction has not yet read, and writes that would land ahead of an older write to the same register. Each unit takes one instruction at a time. Work sent to a unit stays in flight until the completion port reports that unit finished and names the register it wrote. Age is tracked separately from slot position. This lets a freed slot be reused at once while the oldest contender for a unit still wins.

Top module: `ooo_issue_window`

## Requirements
- R1: When `ins_valid` is high and `full` is low, the instruction is stored, even if older buffered instructions are blocked. It can issue at the earliest in the cycle after the one in which it was inserted.
- R2: `full` is high exactly when all DEPTH slots hold an instruction. An insert offered while `full` is high is dropped and never appears on any issue port.
- R3: An instruction for unit u issues only while u is idle. Unit u is busy from its issue cycle until the cycle after a completion with `cmp_unit` = u. Units are numbered 0 to NUM_UNITS-1 and are encoded as binary on `ins_unit` and `cmp_unit`.
- R4: A ready instruction issues even when older instructions in the buffer are blocked.
- R5: An instruction waits while an older buffered instruction writes one of its sources. It also waits while an in-flight instruction has a pending write to one of its sources. A completion naming register `cmp_reg` clears that pending write from the next cycle on.
- R6: An instruction waits while an older buffered instruction reads its destination register.
- R7: An instruction waits while an older buffered instruction, or any in-flight instruction, writes its destination register.
- R8: When several ready instructions target one unit, the one inserted earliest issues, whatever slot it occupies.
- R9: Different units may each issue in the same cycle. An issued instruction leaves the buffer at the end of its issue cycle, so `full` falls in the next cycle.
- R10: After reset the buffer is empty, all units are idle, no register write is pending, `full` is low and no issue port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_unit | input | UNIT_W | Target unit of inserted instruction |
| ins_id | input | ID_W | Tag carried to the issue port |
| ins_dst | input | REG_AW | Destination register |
| ins_src_a | input | REG_AW | First source register |
| ins_src_b | input | REG_AW | Second source register |
| full | output | 1 | All slots occupied; inserts dropped |
| iss_valid | output | NUM_UNITS | Bit u: an instruction issues to unit u this cycle |
| iss_id | output | NUM_UNITS*ID_W | Tag of issued instruction, field u at bits u*ID_W |
| iss_dst | output | NUM_UNITS*REG_AW | Destination of issued instruction, field u at bits u*REG_AW |
| cmp_valid | input | 1 | A unit reports completion |
| cmp_unit | input | UNIT_W | Unit that finished |
| cmp_reg | input | REG_AW | Register that unit wrote |

## Verification
The bench blocks an older instruction on a busy unit and checks that a younger one bound for another unit goes out first. A window that stalls in order would delay it. Separate scenarios place a younger writer behind an older reader of the same register, and behind an older writer of it. A missing anti-dependency check lets the writer out early. A missing output check lets it out while the older write is still buffered or still in flight. One scenario reuses a lower slot for a younger instruction so that slot-index priority would pick the wrong winner. The last scenario fills every slot, offers one more insert, and drains the buffer to show the dropped instruction never issues and that the others leave in program order.

// File: rtl/oow_pkg.sv
package oow_pkg;

   // index width that stays legal for a count of one
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   localparam int DEF_DEPTH     = 8;
   localparam int DEF_NUM_UNITS = 3;
   localparam int DEF_REG_AW    = 3;
   localparam int DEF_ID_W      = 4;

endpackage

// File: rtl/oow_age.sv
module oow_age #(
   parameter int DEPTH = oow_pkg::DEF_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] alloc,
   input  logic [DEPTH-1:0] valid_q,
   output logic [DEPTH-1:0] older [DEPTH]
);

   // older[i][j] = 1 : slot j holds an instruction inserted before slot i
   logic [DEPTH-1:0] older_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < DEPTH; j++) begin
               if (alloc[i])      older_q[i][j] <= valid_q[j];
               else if (alloc[j]) older_q[i][j] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) older[i] = older_q[i];
   end

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
         for (genvar gj = gi + 1; gj < DEPTH; gj++) begin : g_col
            // R8
            age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (valid_q[gi] && valid_q[gj]) |-> (older_q[gi][gj] != older_q[gj][gi]));
         end
      end
   endgenerate

endmodule

// File: rtl/oow_pick.sv
module oow_pick #(
   parameter int DEPTH = oow_pkg::DEF_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] cand,
   input  logic [DEPTH-1:0] older [DEPTH],
   output logic [DEPTH-1:0] grant
);

   // a candidate wins when no other candidate is older than it
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         grant[i] = cand[i] && !(|(cand & older[i]));
      end
   end

   // R8
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R8
   grant_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|cand) |-> (|grant));

endmodule

// File: rtl/oow_score.sv
module oow_score #(
   parameter int NUM_UNITS = oow_pkg::DEF_NUM_UNITS,
   parameter int REG_AW    = oow_pkg::DEF_REG_AW,
   parameter int UNIT_W    = oow_pkg::idx_w(NUM_UNITS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_UNITS-1:0]        iss_valid,
   input  logic [NUM_UNITS*REG_AW-1:0] iss_dst,
   input  logic                        cmp_valid,
   input  logic [UNIT_W-1:0]           cmp_unit,
   input  logic [REG_AW-1:0]           cmp_reg,
   output logic [NUM_UNITS-1:0]        unit_busy,
   output logic [(1<<REG_AW)-1:0]      reg_busy
);

   localparam int NUM_REGS = 1 << REG_AW;

   logic [NUM_UNITS-1:0] unit_q;
   logic [NUM_REGS-1:0]  reg_q;
   logic [NUM_REGS-1:0]  reg_set;

   always_comb begin
      reg_set = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (iss_valid[u]) reg_set[iss_dst[u*REG_AW +: REG_AW]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit_q <= '0;
         reg_q  <= '0;
      end else begin
         for (int u = 0; u < NUM_UNITS; u++) begin
            if (iss_valid[u])                                      unit_q[u] <= 1'b1;
            else if (cmp_valid && (cmp_unit == UNIT_W'(u)))        unit_q[u] <= 1'b0;
         end
         for (int r = 0; r < NUM_REGS; r++) begin
            if (reg_set[r])                                        reg_q[r] <= 1'b1;
            else if (cmp_valid && (cmp_reg == REG_AW'(r)))         reg_q[r] <= 1'b0;
         end
      end
   end

   assign unit_busy = unit_q;
   assign reg_busy  = reg_q;

   generate
      for (genvar gu = 0; gu < NUM_UNITS; gu++) begin : g_unit
         // R3
         unit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[gu] |-> !unit_q[gu]);
         // R7
         dst_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[gu] |-> !reg_q[iss_dst[gu*REG_AW +: REG_AW]]);
      end
   endgenerate

endmodule

// File: rtl/ooo_issue_window.sv
module ooo_issue_window #(
   parameter int DEPTH     = oow_pkg::DEF_DEPTH,
   parameter int NUM_UNITS = oow_pkg::DEF_NUM_UNITS,
   parameter int REG_AW    = oow_pkg::DEF_REG_AW,
   parameter int ID_W      = oow_pkg::DEF_ID_W,
   parameter int UNIT_W    = oow_pkg::idx_w(NUM_UNITS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ins_valid,
   input  logic [UNIT_W-1:0]           ins_unit,
   input  logic [ID_W-1:0]             ins_id,
   input  logic [REG_AW-1:0]           ins_dst,
   input  logic [REG_AW-1:0]           ins_src_a,
   input  logic [REG_AW-1:0]           ins_src_b,
   output logic                        full,
   output logic [NUM_UNITS-1:0]        iss_valid,
   output logic [NUM_UNITS*ID_W-1:0]   iss_id,
   output logic [NUM_UNITS*REG_AW-1:0] iss_dst,
   input  logic                        cmp_valid,
   input  logic [UNIT_W-1:0]           cmp_unit,
   input  logic [REG_AW-1:0]           cmp_reg
);

   localparam int NUM_REGS = 1 << REG_AW;

   initial begin
      depth_param_chk: assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      unit_param_chk:  assert (NUM_UNITS >= 1 && NUM_UNITS <= (1 << UNIT_W))
         else $error("NUM_UNITS does not fit UNIT_W");
   end

   // slot storage
   logic [DEPTH-1:0]  valid_q;
   logic [UNIT_W-1:0] unit_q [DEPTH];
   logic [ID_W-1:0]   id_q   [DEPTH];
   logic [REG_AW-1:0] dst_q  [DEPTH];
   logic [REG_AW-1:0] sa_q   [DEPTH];
   logic [REG_AW-1:0] sb_q   [DEPTH];

   logic [DEPTH-1:0]     older [DEPTH];
   logic [DEPTH-1:0]     alloc;
   logic [DEPTH-1:0]     ready;
   logic [DEPTH-1:0]     issued;
   logic [DEPTH-1:0]     cand  [NUM_UNITS];
   logic [DEPTH-1:0]     grant [NUM_UNITS];
   logic [NUM_UNITS-1:0] unit_busy;
   logic [NUM_REGS-1:0]  reg_busy;
   logic                 accept;

   assign full   = &valid_q;
   assign accept = ins_valid && !full;

   // lowest free slot takes the new instruction
   always_comb begin
      logic found;
      found = 1'b0;
      alloc = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!valid_q[i] && !found) begin
            alloc[i] = accept;
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            unit_q[i] <= '0;
            id_q[i]   <= '0;
            dst_q[i]  <= '0;
            sa_q[i]   <= '0;
            sb_q[i]   <= '0;
         end
      end else begin
         valid_q <= (valid_q & ~issued) | alloc;
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc[i]) begin
               unit_q[i] <= ins_unit;
               id_q[i]   <= ins_id;
               dst_q[i]  <= ins_dst;
               sa_q[i]   <= ins_src_a;
               sb_q[i]   <= ins_src_b;
            end
         end
      end
   end

   oow_age #(.DEPTH(DEPTH)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc   (alloc),
      .valid_q (valid_q),
      .older   (older)
   );

   oow_score #(.NUM_UNITS(NUM_UNITS), .REG_AW(REG_AW), .UNIT_W(UNIT_W)) u_score (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .iss_dst   (iss_dst),
      .cmp_valid (cmp_valid),
      .cmp_unit  (cmp_unit),
      .cmp_reg   (cmp_reg),
      .unit_busy (unit_busy),
      .reg_busy  (reg_busy)
   );

   // readiness: unit idle, no pending write on any operand, no hazard against older slots
   always_comb begin
      logic blk;
      for (int i = 0; i < DEPTH; i++) begin
         blk = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (valid_q[j] && older[i][j]) begin
               if (dst_q[j] == sa_q[i] || dst_q[j] == sb_q[i]) blk = 1'b1; // read after write
               if (sa_q[j] == dst_q[i] || sb_q[j] == dst_q[i]) blk = 1'b1; // write after read
               if (dst_q[j] == dst_q[i])                       blk = 1'b1; // write after write
            end
         end
         ready[i] = valid_q[i] && !blk && !unit_busy[unit_q[i]]
                 && !reg_busy[sa_q[i]] && !reg_busy[sb_q[i]] && !reg_busy[dst_q[i]];
      end
   end

   generate
      for (genvar gu = 0; gu < NUM_UNITS; gu++) begin : g_port
         always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
               cand[gu][i] = ready[i] && (unit_q[i] == UNIT_W'(gu));
            end
         end

         oow_pick #(.DEPTH(DEPTH)) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .cand  (cand[gu]),
            .older (older),
            .grant (grant[gu])
         );

         always_comb begin
            iss_valid[gu]                    = |grant[gu];
            iss_id[gu*ID_W +: ID_W]          = '0;
            iss_dst[gu*REG_AW +: REG_AW]     = '0;
            for (int i = 0; i < DEPTH; i++) begin
               if (grant[gu][i]) begin
                  iss_id[gu*ID_W +: ID_W]      = iss_id[gu*ID_W +: ID_W] | id_q[i];
                  iss_dst[gu*REG_AW +: REG_AW] = iss_dst[gu*REG_AW +: REG_AW] | dst_q[i];
               end
            end
         end
      end
   endgenerate

   always_comb begin
      issued = '0;
      for (int u = 0; u < NUM_UNITS; u++) issued = issued | grant[u];
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && full) |=> ($countones(valid_q) <= $past($countones(valid_q))));

   // R9
   slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|iss_valid) && !accept) |=> ($countones(valid_q) < $past($countones(valid_q))));

   // R1
   insert_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !(|iss_valid)) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

endmodule

// File: tb/ooo_issue_window_tb.sv
module ooo_issue_window_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ins_valid = 1'b0;
   logic [1:0] ins_unit = '0;
   logic [3:0] ins_id = '0;
   logic [2:0] ins_dst = '0;
   logic [2:0] ins_src_a = '0;
   logic [2:0] ins_src_b = '0;
   logic       full;
   logic [2:0] iss_valid;
   logic [11:0] iss_id;
   logic [8:0]  iss_dst;
   logic       cmp_valid = 1'b0;
   logic [1:0] cmp_unit = '0;
   logic [2:0] cmp_reg = '0;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   ooo_issue_window u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_valid (ins_valid),
      .ins_unit  (ins_unit),
      .ins_id    (ins_id),
      .ins_dst   (ins_dst),
      .ins_src_a (ins_src_a),
      .ins_src_b (ins_src_b),
      .full      (full),
      .iss_valid (iss_valid),
      .iss_id    (iss_id),
      .iss_dst   (iss_dst),
      .cmp_valid (cmp_valid),
      .cmp_unit  (cmp_unit),
      .cmp_reg   (cmp_reg)
   );

   task automatic nxt();
      @(posedge clk);
      #1;
      ins_valid = 1'b0;
      cmp_valid = 1'b0;
   endtask

   task automatic ins(input int id, input int unit, input int dst, input int sa, input int sb);
      ins_valid = 1'b1;
      ins_id    = 4'(id);
      ins_unit  = 2'(unit);
      ins_dst   = 3'(dst);
      ins_src_a = 3'(sa);
      ins_src_b = 3'(sb);
   endtask

   task automatic cmp(input int unit, input int r);
      cmp_valid = 1'b1;
      cmp_unit  = 2'(unit);
      cmp_reg   = 3'(r);
   endtask

   task automatic chk_none(input string req);
      checks++;
      if (iss_valid !== 3'b000) begin
         fails++;
         $display("FAIL %s: iss_valid=%b expected 000", req, iss_valid);
      end
   endtask

   task automatic chk_one(input string req, input int unit, input int id);
      logic [2:0] ev;
      ev = 3'(1 << unit);
      checks++;
      if (iss_valid !== ev || iss_id[unit*4 +: 4] !== 4'(id)) begin
         fails++;
         $display("FAIL %s: iss_valid=%b id=%0d expected %b id=%0d",
                  req, iss_valid, iss_id[unit*4 +: 4], ev, id);
      end
   endtask

   task automatic chk_full(input string req, input logic e);
      checks++;
      if (full !== e) begin
         fails++;
         $display("FAIL %s: full=%b expected %b", req, full, e);
      end
   endtask

   task automatic t_reset();
      chk_full("R10 reset full", 1'b0);
      chk_none("R10 reset issue");
   endtask

   // younger instruction bound to a free unit passes a blocked older one
   task automatic t_bypass();
      ins(1, 0, 1, 2, 3);                nxt();
      chk_one("R1 first issue", 0, 1);
      ins(2, 0, 4, 5, 6);                nxt();
      ins(3, 1, 7, 5, 6);
      chk_none("R3 unit0 busy");         nxt();
      chk_one("R4 younger passes", 1, 3); nxt();
      cmp(0, 1);
      chk_none("R3 both busy");          nxt();
      chk_one("R3 unit0 freed", 0, 2);   nxt();
      cmp(0, 4);                         nxt();
      cmp(1, 7);                         nxt();
   endtask

   task automatic t_true_dep();
      ins(4, 0, 1, 2, 3);                nxt();
      chk_one("R5 producer", 0, 4);
      ins(5, 1, 5, 1, 2);                nxt();
      cmp(0, 1);
      chk_none("R5 waits on pending write"); nxt();
      chk_one("R5 after completion", 1, 5); nxt();
      cmp(1, 5);                         nxt();
   endtask

   task automatic t_anti_dep();
      ins(6, 0, 6, 6, 6);                nxt();
      chk_one("R6 blocker", 0, 6);
      ins(7, 0, 1, 3, 2);                nxt();
      ins(8, 1, 3, 4, 4);
      chk_none("R6 setup");              nxt();
      cmp(0, 6);
      chk_none("R6 writer held by older reader"); nxt();
      chk_one("R6 reader goes first", 0, 7); nxt();
      chk_one("R6 writer after reader", 1, 8); nxt();
      cmp(0, 1);                         nxt();
      cmp(1, 3);                         nxt();
   endtask

   task automatic t_out_dep();
      ins(9, 0, 6, 6, 6);                nxt();
      chk_one("R7 blocker", 0, 9);
      ins(10, 0, 2, 7, 7);               nxt();
      ins(11, 1, 2, 4, 5);
      chk_none("R7 setup");              nxt();
      cmp(0, 6);
      chk_none("R7 buffered older writer"); nxt();
      chk_one("R7 older writer", 0, 10); nxt();
      cmp(0, 2);
      chk_none("R7 in-flight older writer"); nxt();
      chk_one("R7 younger writer", 1, 11); nxt();
      cmp(1, 2);                         nxt();
   endtask

   // younger instruction lands in a lower slot than the older one
   task automatic t_age();
      ins(12, 2, 6, 6, 6);               nxt();
      chk_one("R8 blocker", 2, 12);
      ins(1, 2, 1, 3, 3);                nxt();
      ins(2, 2, 2, 4, 4);
      chk_none("R8 setup");              nxt();
      cmp(2, 6);
      chk_none("R8 unit2 busy");         nxt();
      chk_one("R8 oldest wins", 2, 1);   nxt();
      cmp(2, 1);                         nxt();
      chk_one("R8 next oldest", 2, 2);   nxt();
      cmp(2, 2);                         nxt();
   endtask

   task automatic t_parallel();
      ins(3, 0, 3, 0, 0);                nxt();
      chk_one("R9 blocker", 0, 3);
      ins(4, 1, 4, 3, 3);                nxt();
      ins(5, 2, 5, 3, 3);
      chk_none("R9 setup");              nxt();
      cmp(0, 3);
      chk_none("R5 both wait");          nxt();
      checks++;
      if (iss_valid !== 3'b110 || iss_id[7:4] !== 4'd4 || iss_id[11:8] !== 4'd5) begin
         fails++;
         $display("FAIL R9 dual issue: iss_valid=%b ids=%0d,%0d expected 110 ids=4,5",
                  iss_valid, iss_id[7:4], iss_id[11:8]);
      end
      nxt();
      cmp(1, 4);                         nxt();
      cmp(2, 5);                         nxt();
   endtask

   task automatic t_fill();
      int prev;
      ins(14, 0, 0, 0, 0);               nxt();
      chk_one("R2 blocker", 0, 14);
      for (int k = 0; k < 8; k++) begin
         if (k == 7) chk_full("R2 seven held", 1'b0);
         ins(k, 0, k, k, k);             nxt();
      end
      chk_full("R2 all slots held", 1'b1);
      ins(15, 0, 7, 7, 7);               nxt();
      chk_full("R2 still full", 1'b1);
      chk_none("R2 nothing ready");      nxt();
      prev = 0;
      for (int k = 0; k < 8; k++) begin
         cmp(0, prev);
         if (k == 1) chk_full("R9 full falls", 1'b0);
         chk_none("R3 wait completion"); nxt();
         chk_one("R8 drain order", 0, k); nxt();
         prev = k;
      end
      cmp(0, prev);                      nxt();
      chk_none("R2 dropped insert never issues");
      chk_full("R2 empty after drain", 1'b0);
      nxt();
      chk_none("R2 still idle");
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      nxt();
      t_bypass();
      t_true_dep();
      t_anti_dep();
      t_out_dep();
      t_age();
      t_parallel();
      t_fill();
      summary();
      $finish;
   end

endmodule